// File: doc/BRIEF.md
# Dual-Clock FIFO with Two-Pin Fill Status

This block is a first-in first-out buffer whose write port and read port run on clocks with no fixed relation to each other. Each port has its own active-low enable. A word presented with the write enable low is stored on the write-clock edge. A word is handed out on the read-clock edge when the read enable is low and the status does not show Empty. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchronizer.

The fill level is not shown as separate empty and full pins. It is encoded on two status outputs, both registered on the read clock. A write reaches the status only once its pointer has passed the synchronizer. When the buffer shows Empty and a new write becomes visible, the next read-clock edge is a refresh-only cycle. On that edge the status leaves Empty, and the read pointer and data output stay as they are, whatever the read enable does. The first word comes out on the edge after that.

An asynchronous active-low reset clears both pointers, sets the status to Empty and forces the data output to zero. Both enables must be held inactive while reset is low.

Top module: `dcfifo_enc_flags`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_data` is 0 and {`flag_a`,`flag_b`} is 2'b00 (Empty), until words are written.
- R2: Words come out on `rd_data` in exactly the order in which they were accepted on the write side, with no loss and no duplication.
- R3: With N words held as seen by the read side, {`flag_a`,`flag_b`} reads 2'b00 for N=0, 2'b10 for 1≤N≤8, 2'b11 for 9≤N≤503, 2'b10 for 504≤N≤511, and 2'b01 for N=512.
- R4: A read-clock edge with `rd_en_n` low while the status shows Empty is ignored: `rd_data` keeps its value and no stored word is consumed.
- R5: A write attempted while 512 words are held is discarded. It does not appear in the data later read out.
- R6: The read-clock edge on which the status leaves Empty is a refresh-only cycle: `rd_data` is unchanged on that edge even with `rd_en_n` held low.
- R7: On a read-clock edge with `rd_en_n` low and the status not Empty, `rd_data` takes the next stored word. With `rd_en_n` high, `rd_data` holds. A read of the last word returns the status to 2'b00.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 9 | Word to store |
| rd_clk | input | 1 | Read-side clock; also clocks the status outputs |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | 9 | Registered output word |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_a | output | 1 | Status bit, high bit of the encoded fill state |
| flag_b | output | 1 | Status bit, low bit of the encoded fill state |

## Verification
The bench holds the read enable low across the Empty-to-non-empty transition. A design without the refresh-only cycle would change `rd_data` on the edge where the status first leaves Empty, or would report the data one cycle early. It fills the buffer past 512 words and then drains it. A design that accepted a write while full would produce a surplus word or corrupt the order on the way out. It samples the status at the boundary levels 8/9 and 503/504/511/512, where an off-by-one threshold or a wrong pin encoding shows up directly. Random reads and writes on two unrelated clock periods, compared against a reference queue, expose pointer crossing faults as lost, repeated or reordered words.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY  = 2'b00,
    FILL_FULL   = 2'b01,
    FILL_NEAR   = 2'b10,
    FILL_MIDDLE = 2'b11
  } fill_code_t;

  // Maps a word count seen on the read side to the two-pin status code.
  function automatic fill_code_t fill_code(input int unsigned cnt,
                                           input int unsigned depth,
                                           input int unsigned low_max,
                                           input int unsigned high_min);
    if (cnt == 0)                              return FILL_EMPTY;
    else if (cnt >= depth)                     return FILL_FULL;
    else if (cnt <= low_max || cnt >= high_min) return FILL_NEAR;
    else                                       return FILL_MIDDLE;
  endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  logic [PW-1:0] stage1, stage2;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = gray_to_bin(stage2);

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int AW = 9
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [AW:0]   rbin,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_fire,
  output logic          full_w
);

  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wnext, used;

  assign used    = wbin - rbin;
  assign full_w  = (used == {1'b1, {AW{1'b0}}});
  assign wr_fire = !wr_en_n && !full_w;
  assign wnext   = wbin + {{AW{1'b0}}, wr_fire};
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int AW       = 9,
  parameter int LOW_MAX  = 8,
  parameter int HIGH_MIN = 504
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic [AW:0]   wbin,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rd_fire,
  output logic [1:0]    status
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin, rnext, held;
  fill_code_t    status_q;

  // Reads are gated by the registered status, so the edge that first
  // sees a new word only refreshes the status (refresh-only cycle).
  assign rd_fire = !rd_en_n && (status_q != FILL_EMPTY);
  assign rnext   = rbin + {{AW{1'b0}}, rd_fire};
  assign held    = wbin - rnext;
  assign raddr   = rbin[AW-1:0];
  assign status  = status_q;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      status_q <= FILL_EMPTY;
    end else begin
      rbin     <= rnext;
      rgray    <= rnext ^ (rnext >> 1);
      status_q <= fill_code(32'(held), DEPTH, LOW_MAX, HIGH_MIN);
    end
  end

endmodule

// File: rtl/dcfifo_enc_flags.sv
module dcfifo_enc_flags #(
  parameter int DATA_W     = 9,
  parameter int ADDR_W     = 9,
  parameter int LOW_MAX    = 8,
  parameter int HIGH_SPARE = 8
) (
  input  logic              wr_clk,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rst_n,
  output logic              flag_a,
  output logic              flag_b
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int HIGH_MIN = DEPTH - HIGH_SPARE;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   wgray, rgray, wbin_rd, rbin_wr;
  logic              wr_fire, full_w, rd_fire;
  logic [1:0]        status;

  dcf_wr_side #(.AW(ADDR_W)) u_wr (
    .wr_clk (wr_clk),
    .rst_n  (rst_n),
    .wr_en_n(wr_en_n),
    .rbin   (rbin_wr),
    .waddr  (waddr),
    .wgray  (wgray),
    .wr_fire(wr_fire),
    .full_w (full_w)
  );

  dcf_gray_sync #(.PW(ADDR_W + 1)) u_w2r (
    .clk    (rd_clk),
    .rst_n  (rst_n),
    .gray_in(wgray),
    .bin_out(wbin_rd)
  );

  dcf_gray_sync #(.PW(ADDR_W + 1)) u_r2w (
    .clk    (wr_clk),
    .rst_n  (rst_n),
    .gray_in(rgray),
    .bin_out(rbin_wr)
  );

  dcf_rd_side #(.AW(ADDR_W), .LOW_MAX(LOW_MAX), .HIGH_MIN(HIGH_MIN)) u_rd (
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .rd_en_n(rd_en_n),
    .wbin   (wbin_rd),
    .raddr  (raddr),
    .rgray  (rgray),
    .rd_fire(rd_fire),
    .status (status)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= mem[raddr];
  end

  assign flag_a = status[1];
  assign flag_b = status[0];

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 9
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_fire,
  input logic              full_w,
  input logic [ADDR_W:0]   wgray,
  input logic              rd_fire,
  input logic [ADDR_W:0]   rgray,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag_a,
  input logic              flag_b
);

  assert_empty_keeps_data_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!flag_a && !flag_b) |=> $stable(rd_data));

  assert_idle_keeps_data_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));

  assert_read_moves_ptr_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_fire |=> (rgray != $past(rgray)));

  assert_full_holds_ptr_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_w |=> $stable(wgray));

  assert_wr_gray_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));

  assert_rd_gray_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));

  assert_write_seen_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_fire |=> (wgray != $past(wgray)));

endmodule

bind dcfifo_enc_flags dcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk (wr_clk),
  .rd_clk (rd_clk),
  .rst_n  (rst_n),
  .wr_fire(wr_fire),
  .full_w (full_w),
  .wgray  (wgray),
  .rd_fire(rd_fire),
  .rgray  (rgray),
  .rd_data(rd_data),
  .flag_a (flag_a),
  .flag_b (flag_b)
);

// File: tb/dcfifo_enc_flags_test.sv
`timescale 1ns/1ps
module dcfifo_enc_flags_test;

  localparam int DEPTH    = 512;
  localparam int LOW_MAX  = 8;
  localparam int HIGH_MIN = 504;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic       wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [8:0] wr_data = '0;
  wire  [8:0] rd_data;
  wire        flag_a, flag_b;

  dcfifo_enc_flags uut (
    .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .rst_n(rst_n), .flag_a(flag_a), .flag_b(flag_b)
  );

  always #2.5 rd_clk = ~rd_clk;   // 200 MHz
  always #3.5 wr_clk = ~wr_clk;   // unrelated write clock

  int         checks = 0, failures = 0;
  logic [8:0] ref_q[$];
  bit         mon_on = 0;
  int         rd_mode = 0;        // 0 idle, 1 always read, 2 random
  bit         pend = 0;
  logic [8:0] last_data = '0;
  logic [1:0] prev_st = 2'b00;

  function automatic logic [1:0] exp_code(input int n);
    if (n == 0)                          return 2'b00;
    if (n >= DEPTH)                      return 2'b01;
    if (n <= LOW_MAX || n >= HIGH_MIN)   return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_word(input logic [8:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    if (ref_q.size() < DEPTH) ref_q.push_back(d);
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic drain;
    rd_mode = 1;
    while (ref_q.size() != 0) @(negedge rd_clk);
    rd_wait(10);
    rd_mode = 0;
    rd_wait(2);
  endtask

  // Read-side monitor: drives rd_en_n and checks rd_data every cycle.
  initial begin
    forever begin
      @(negedge rd_clk);
      if (mon_on) begin
        logic [1:0] st;
        string tag;
        st = {flag_a, flag_b};
        if (pend) begin
          if (ref_q.size() == 0) begin
            check(1'b0, "R5 read returned a word never accepted", int'(rd_data), -1);
          end else begin
            logic [8:0] e;
            e = ref_q.pop_front();
            check(rd_data == e, "R2 R7 read data order", int'(rd_data), int'(e));
          end
        end else begin
          if (prev_st == 2'b00 && st != 2'b00) tag = "R6 refresh-only cycle changed data";
          else if (prev_st == 2'b00)           tag = "R4 read while empty changed data";
          else                                 tag = "R7 data moved without a read";
          check(rd_data == last_data, tag, int'(rd_data), int'(last_data));
        end
        case (rd_mode)
          1:       rd_en_n = 1'b0;
          2:       rd_en_n = 1'($urandom % 2);
          default: rd_en_n = 1'b1;
        endcase
        pend      = !rd_en_n && (st != 2'b00);
        last_data = rd_data;
        prev_st   = st;
      end else begin
        rd_en_n   = 1'b1;
        pend      = 1'b0;
        last_data = rd_data;
        prev_st   = {flag_a, flag_b};
      end
    end
  end

  initial begin
    #(200000.0 * 5.0);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int targets[8] = '{1, 8, 9, 503, 504, 511, 512, 515};
    int n;
    void'($urandom(32'd2024));

    // R1: reset state
    rd_wait(3);
    check(rd_data == 9'd0, "R1 rd_data in reset", int'(rd_data), 0);
    check({flag_a, flag_b} == 2'b00, "R1 status in reset", int'({flag_a, flag_b}), 0);
    rst_n = 1'b1;
    rd_wait(4);
    check(rd_data == 9'd0, "R1 rd_data after reset", int'(rd_data), 0);
    check({flag_a, flag_b} == 2'b00, "R1 status after reset", int'({flag_a, flag_b}), 0);
    mon_on = 1;

    // R4 / R6 / R7: read held low across empty, single word arrival
    rd_mode = 1;
    rd_wait(8);
    wr_word(9'h1A5);
    rd_wait(20);
    check(ref_q.size() == 0, "R7 single word consumed", ref_q.size(), 0);
    check({flag_a, flag_b} == 2'b00, "R7 empty after last read", int'({flag_a, flag_b}), 0);
    check(rd_data == 9'h1A5, "R7 single word on output", int'(rd_data), 9'h1A5);
    rd_mode = 0;
    rd_wait(2);

    // R3 / R5: fill with reads off, check status at boundary levels
    n = 0;
    foreach (targets[i]) begin
      while (n < targets[i]) begin
        wr_word(9'($urandom));
        n++;
      end
      rd_wait(10);
      check({flag_a, flag_b} == exp_code(n > DEPTH ? DEPTH : n), "R3 status at fill level",
            int'({flag_a, flag_b}), int'(exp_code(n > DEPTH ? DEPTH : n)));
    end
    check(ref_q.size() == DEPTH, "R5 model holds full depth", ref_q.size(), DEPTH);
    drain();
    check({flag_a, flag_b} == 2'b00, "R7 empty after drain", int'({flag_a, flag_b}), 0);

    // R2: random traffic on both clocks
    rd_mode = 2;
    for (int k = 0; k < 800; k++) begin
      while (ref_q.size() > 300) @(negedge wr_clk);
      if ($urandom % 3 == 0) @(negedge wr_clk);
      wr_word(9'($urandom));
    end
    drain();
    check({flag_a, flag_b} == 2'b00, "R2 empty after random traffic", int'({flag_a, flag_b}), 0);

    // R1: reset with words stored and a nonzero output
    for (int k = 0; k < 5; k++) wr_word(9'(k * 37 + 3));
    rd_wait(10);
    rd_mode = 1;
    rd_wait(2);
    rd_mode = 0;
    rd_wait(3);
    mon_on = 0;
    rd_wait(2);
    rst_n = 1'b0;
    #1;
    check(rd_data == 9'd0, "R1 rd_data cleared by reset", int'(rd_data), 0);
    check({flag_a, flag_b} == 2'b00, "R1 status cleared by reset", int'({flag_a, flag_b}), 0);
    ref_q.delete();
    rd_wait(4);
    rst_n = 1'b1;
    rd_wait(4);
    mon_on = 1;
    for (int k = 0; k < 3; k++) wr_word(9'(k + 100));
    rd_wait(10);
    check({flag_a, flag_b} == 2'b10, "R3 three words after reset", int'({flag_a, flag_b}), 2);
    drain();
    check({flag_a, flag_b} == 2'b00, "R2 empty after post-reset drain", int'({flag_a, flag_b}), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule